// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog for a larger system. It sits on a simple single-cycle register bus and counts a 16-bit value down toward zero. Two clock-enable stages slow the count. The first is an 8-bit programmable prescaler that divides by P+1. The second is a power-of-two divider that can be set to 16, 32, 64 or 128. The stages produce one-cycle enable pulses. They do not produce derived clocks, so the whole block runs on a single clock.

Software services the watchdog by writing the live count register before the count runs out. If the count does run out, the block reloads the count from a separate reload register. It can then raise a one-cycle interrupt pulse, a system-reset request held for a fixed number of cycles, or both. Each of these two outputs has its own enable bit.

Top module: `wdog_timer`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control), 0x04 (reload) and 0x08 (live count). After reset, control reads 0x0000_8019 and both reload and count read 0x0000_8000.
- R2: The control bits are laid out as follows. Bit 0 enables the reset request and bit 2 enables the interrupt. Bits 4:3 select the divider and bit 5 starts the timer. Bits 15:8 hold the prescale value P. All other control bits read as zero.
- R3: While running, the count drops by one every (P+1)·(16<<sel) clock cycles. The interval is measured from the edge on which the timer was started or the count was last written. Here sel is control bits 4:3.
- R4: A bus write to the count register loads bits 15:0 into the count at that edge and restarts both prescaler stages. This is the keep-alive action.
- R5: While bit 5 is clear, the count holds its value and the prescaler stages are held cleared.
- R6: A write to the reload register does not change the live count.
- R7: A tick that finds the count at 1 or 0 is an expiry. On expiry the count takes the reload value. If bit 2 is set, irq_pulse is high for exactly the one cycle after that edge.
- R8: On expiry with bit 0 set, rst_req goes high on the same cycle as the interrupt would, and stays high for 128 cycles. Without bit 0 set, rst_req stays low.
- R9: Any other address reads as zero, and writes to it change no register.
- R10: A count-register write on the same edge as a tick wins. The written value is loaded, and any expiry from that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_pulse | output | 1 | One-cycle expiry interrupt |
| rst_req | output | 1 | Reset request held for 128 cycles |

## Verification
The keep-alive write to the count register can land on the very edge where a decrement tick fires. The hardest case is when that tick would also expire the timer. The bench sets a count of 1 with the fastest divider setting and starts the timer. It then times a count write to land exactly sixteen edges later. It judges the result by three observations: the written value reads back unchanged, no interrupt or reset pulse appears, and the next decrement comes a full sixteen cycles after the write.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 8,
  parameter int RST_HOLD = 128,
  parameter logic [CNT_W-1:0] LOAD_INIT = 16'h8000,
  parameter logic [PRE_W-1:0] PRE_INIT  = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse,
  output logic              rst_req
);
  localparam int DIV_W  = 7;
  localparam int HOLD_W = $clog2(RST_HOLD + 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(8);

  logic             rst_en_q, irq_en_q, run_q;
  logic [1:0]       div_sel_q;
  logic [PRE_W-1:0] pre_val_q, pre_cnt_q;
  logic [DIV_W-1:0] div_cnt_q, div_mask;
  logic [CNT_W-1:0] load_q, cnt_q;
  logic [HOLD_W-1:0] hold_q;
  logic             irq_q;

  wire ctrl_wr = bus_we && bus_addr == A_CTRL;
  wire load_wr = bus_we && bus_addr == A_LOAD;
  wire cnt_wr  = bus_we && bus_addr == A_CNT;

  always_comb begin
    case (div_sel_q)
      2'd0:    div_mask = DIV_W'(15);
      2'd1:    div_mask = DIV_W'(31);
      2'd2:    div_mask = DIV_W'(63);
      default: div_mask = DIV_W'(127);
    endcase
  end

  wire pre_hit = pre_cnt_q >= pre_val_q;
  wire tick    = run_q && pre_hit && ((div_cnt_q & div_mask) == div_mask);
  wire expire  = tick && !cnt_wr && cnt_q <= CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_en_q  <= 1'b1;
      irq_en_q  <= 1'b0;
      run_q     <= 1'b0;
      div_sel_q <= 2'd3;
      pre_val_q <= PRE_INIT;
    end else if (ctrl_wr) begin
      rst_en_q  <= bus_wdata[0];
      irq_en_q  <= bus_wdata[2];
      div_sel_q <= bus_wdata[4:3];
      run_q     <= bus_wdata[5];
      pre_val_q <= bus_wdata[8 +: PRE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_q <= LOAD_INIT;
    else if (load_wr) load_q <= bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt_q <= '0;
      div_cnt_q <= '0;
    end else if (!run_q || cnt_wr) begin
      pre_cnt_q <= '0;
      div_cnt_q <= '0;
    end else if (pre_hit) begin
      pre_cnt_q <= '0;
      div_cnt_q <= div_cnt_q + DIV_W'(1);
    end else begin
      pre_cnt_q <= pre_cnt_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LOAD_INIT;
    else if (cnt_wr) cnt_q <= bus_wdata[CNT_W-1:0];
    else if (expire) cnt_q <= load_q;
    else if (tick)   cnt_q <= cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      irq_q <= expire && irq_en_q;
      if (expire && rst_en_q) hold_q <= HOLD_W'(RST_HOLD);
      else if (hold_q != '0)  hold_q <= hold_q - HOLD_W'(1);
    end
  end

  assign irq_pulse = irq_q;
  assign rst_req   = hold_q != '0;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[0]          = rst_en_q;
        bus_rdata[2]          = irq_en_q;
        bus_rdata[4:3]        = div_sel_q;
        bus_rdata[5]          = run_q;
        bus_rdata[8 +: PRE_W] = pre_val_q;
      end
      A_LOAD:  bus_rdata[CNT_W-1:0] = load_q;
      A_CNT:   bus_rdata[CNT_W-1:0] = cnt_q;
      default: bus_rdata = '0;
    endcase
  end

  assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_wr) |=> cnt_q == $past(cnt_q));
  assert_write_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(bus_wdata[CNT_W-1:0]));
  assert_reload_on_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt_q <= CNT_W'(1)) |=> cnt_q == $past(load_q));
  assert_irq_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pulse) |-> $past(irq_en_q));
  assert_rst_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(rst_en_q));
  assert_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_wr) |=> !irq_pulse);
  always_comb if (rst_n && bus_addr != A_CTRL && bus_addr != A_LOAD && bus_addr != A_CNT)
    assert_unmapped_zero_R9: assert (bus_rdata == '0);
endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_pulse, rst_req;
  int checks = 0, failures = 0, cyc = 0, irq_seen = 0, rst_seen = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (irq_pulse) irq_seen++;
    if (rst_req) rst_seen++;
  end

  wdog_timer u_wdog_timer (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata,
                           .bus_rdata, .irq_pulse, .rst_req);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0; #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl(int p, int s, bit run, bit ie, bit re);
    return (32'(p) << 8) | (32'(s) << 3) | (32'(run) << 5) | (32'(ie) << 2) | 32'(re);
  endfunction

  initial begin
    #750000;
    failures++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int w, d, n, irq0, rst0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    rd(4'h0, v); chk(v == 32'h8019, "R1 ctrl reset", v, 32'h8019);
    rd(4'h4, v); chk(v == 32'h8000, "R1 reload reset", v, 32'h8000);
    rd(4'h8, v); chk(v == 32'h8000, "R1 count reset", v, 32'h8000);

    wr(4'hC, 32'hFFFF_FFFF); wr(4'h1, 32'hFFFF_FFFF);
    rd(4'hC, v); chk(v == 0, "R9 unmapped read", v, 0);
    rd(4'h0, v); chk(v == 32'h8019, "R9 ctrl untouched", v, 32'h8019);
    rd(4'h4, v); chk(v == 32'h8000, "R9 reload untouched", v, 32'h8000);
    rd(4'h8, v); chk(v == 32'h8000, "R9 count untouched", v, 32'h8000);

    wr(4'h0, 32'hFFFF_FFDF);
    rd(4'h0, v); chk(v == 32'hFF1D, "R2 field layout", v, 32'hFF1D);

    // R3 R7 sweep over prescale and divider
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 4; s++) begin
        wr(4'h0, ctl(p, s, 0, 1, 0));
        wr(4'h8, 32'd3);
        wr(4'h4, 32'd7);
        wr(4'h0, ctl(p, s, 1, 1, 0));
        w = cyc; d = -1;
        for (int k = 0; k < 5000; k++) begin
          @(negedge clk);
          if (irq_pulse) begin d = cyc - w; break; end
        end
        chk(d == 3 * (p + 1) * (16 << s), "R3 expiry period", d, 3 * (p + 1) * (16 << s));
        @(negedge clk);
        chk(!irq_pulse, "R7 irq one cycle", irq_pulse, 0);
        rd(4'h8, v); chk(v == 7, "R7 reload on expiry", v, 7);
      end
    end

    // R5 R6 hold while stopped
    wr(4'h0, ctl(0, 0, 0, 0, 0));
    wr(4'h8, 32'd100);
    wr(4'h0, ctl(0, 0, 1, 0, 0));
    repeat (40) @(posedge clk);
    rd(4'h8, v); chk(v == 98, "R3 two decrements", v, 98);
    wr(4'h0, ctl(0, 0, 0, 0, 0));
    repeat (100) @(posedge clk);
    rd(4'h8, v); chk(v == 98, "R5 hold stopped", v, 98);
    wr(4'h4, 32'h55);
    rd(4'h8, v); chk(v == 98, "R6 reload write no effect", v, 98);
    rd(4'h4, v); chk(v == 32'h55, "R6 reload readback", v, 32'h55);
    wr(4'h0, ctl(0, 0, 1, 0, 0));
    repeat (15) @(posedge clk);
    rd(4'h8, v); chk(v == 98, "R5 chain cleared", v, 98);
    @(posedge clk);
    rd(4'h8, v); chk(v == 97, "R5 first tick after restart", v, 97);

    // R4 keep-alive
    wr(4'h0, ctl(0, 0, 0, 1, 1));
    wr(4'h8, 32'd2);
    irq0 = irq_seen; rst0 = rst_seen;
    wr(4'h0, ctl(0, 0, 1, 1, 1));
    for (int k = 0; k < 10; k++) begin
      repeat (20) @(posedge clk);
      wr(4'h8, 32'd2);
    end
    rd(4'h8, v); chk(v == 2, "R4 immediate load", v, 2);
    chk(irq_seen == irq0 && rst_seen == rst0, "R4 no expiry", irq_seen - irq0, 0);

    // R8 reset only
    wr(4'h0, ctl(0, 0, 0, 0, 1));
    wr(4'h8, 32'd1);
    irq0 = irq_seen;
    wr(4'h0, ctl(0, 0, 1, 0, 1));
    w = cyc; d = -1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (rst_req) begin d = cyc - w; break; end
    end
    chk(d == 16, "R8 reset start", d, 16);
    n = 0;
    while (rst_req && n < 400) begin n++; @(negedge clk); end
    chk(n == 128, "R8 reset length", n, 128);
    chk(irq_seen == irq0, "R8 irq disabled", irq_seen - irq0, 0);

    // R8 R7 both enabled rise together
    wr(4'h0, ctl(0, 0, 0, 1, 1));
    wr(4'h8, 32'd1);
    wr(4'h0, ctl(0, 0, 1, 1, 1));
    d = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (irq_pulse || rst_req) begin d = {30'd0, irq_pulse, rst_req}; break; end
    end
    chk(d == 3, "R8 irq and reset together", d, 3);
    wr(4'h0, ctl(0, 0, 0, 1, 1));
    repeat (140) @(posedge clk);

    // R10 collision: count write on expiring tick edge
    wr(4'h8, 32'd1);
    irq0 = irq_seen; rst0 = rst_seen;
    wr(4'h0, ctl(0, 0, 1, 1, 1));
    repeat (15) @(posedge clk);
    wr(4'h8, 32'h40);
    rd(4'h8, v); chk(v == 32'h40, "R10 write wins", v, 32'h40);
    repeat (15) @(posedge clk);
    rd(4'h8, v); chk(v == 32'h40, "R10 chain restarted", v, 32'h40);
    @(posedge clk);
    rd(4'h8, v); chk(v == 32'h3F, "R10 next tick", v, 32'h3F);
    chk(irq_seen == irq0 && rst_seen == rst0, "R10 expiry dropped", irq_seen - irq0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule